// File: doc/BRIEF.md
# Power and Sleep Controller

This block controls the power state of one power domain and the clock and reset state of one module inside that domain. Software uses a simple word-wide register bus. It stages the requested module state and the local reset control in one register, and the domain power-on request in another. Neither takes effect until software writes a go bit for the domain to the command register.

After the go bit is written, the block runs a transition of fixed length. During the transition, a per-domain busy bit reads as one. When the transition ends, the module state and the domain power state are loaded together from the staged values. Two status registers report the results, and two outputs follow them: the module clock enable and the module local reset. Status reads let software poll for completion and confirm the state that was reached.

Module state codes are 0 (reset, clock off), 1 (synchronous reset), 2 (disabled) and 3 (enabled).

Top module: `pwrslp_ctrl`

## Requirements
- R1: After reset, these registers read zero: domain status (0x200), module status (0x800), module control (0xA00), domain control (0x300) and transition status (0x128). After reset, `mod_clk_en` is 0 and `mod_lrst` is 1.
- R2: Module control at 0xA00 stores these bits and reads them back: bits [5:0] (requested state), bit 8 (local reset release, active high) and bit 31 (force). All other bits read 0. Bit 31 has no effect on any state or output.
- R3: Domain control at 0x300 stores bit 0 (power-on request) and reads it back. All other bits read 0.
- R4: A write to the command register at 0x120 with bit DOM_ID set starts a transition while the block is idle. Bit DOM_ID of the transition status register at 0x128 then reads 1 for exactly XFER_CYCLES cycles (default 8) and 0 afterwards.
- R5: The state changes only at the end of a transition. Module status bits [5:0] then take the requested state. Domain status bits [4:0] become 1 if domain control bit 0 is set, and 0 otherwise. Before that point, neither status changes.
- R6: A command write during a transition is ignored, and the transition keeps its length. Command bits other than DOM_ID never start a transition.
- R7: Module status bit 12 is 1 exactly when the module state is 3 and the domain is on.
- R8: `mod_clk_en` is 1 exactly when the module state is 3 and the domain is on, one cycle after that condition.
- R9: `mod_lrst` is 1 exactly when module control bit 8 is 0 or the module state is 0 or 1, one cycle after that condition.
- R10: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read. Unmapped offsets, including 0x120, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| mod_clk_en | output | 1 | Module clock enable |
| mod_lrst | output | 1 | Module local reset, active high |

## Verification
Transitions are run with several combinations of staged values: enabled with the domain on, disabled with local reset held, enabled with the domain off, and synchronous reset with reset released. These separate the clock-enable rule from the local-reset rule, and separate the domain condition from the module condition. The busy bit is polled on every cycle while a second command write lands mid-transition. This shows both that the transition length is exact and that repeated commands are ignored. Writes of all ones show which bits are stored. A command bit for a foreign domain shows that only the matching bit starts a transition.

// File: rtl/pwrslp_pkg.sv
package pwrslp_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int STATE_W = 6;

  localparam logic [ADDR_W-1:0] OFS_GO    = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_BUSY  = 12'h128;
  localparam logic [ADDR_W-1:0] OFS_DSTAT = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_DCTL  = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_MCTL  = 12'hA00;

  localparam int LRSTN_BIT = 8;
  localparam int FORCE_BIT = 31;
  localparam int CLKON_BIT = 12;

  typedef enum logic [STATE_W-1:0] {
    MS_OFF     = 6'd0,
    MS_SYNCRST = 6'd1,
    MS_DISABLE = 6'd2,
    MS_ENABLE  = 6'd3
  } mod_state_e;
endpackage

// File: rtl/pwrslp_xfer_seq.sv
module pwrslp_xfer_seq #(
  parameter int XFER_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(XFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end
  end
endmodule

// File: rtl/pwrslp_state.sv
module pwrslp_state
  import pwrslp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  logic [STATE_W-1:0] req_state,
  input  logic               req_dom_on,
  input  logic               lrst_release,
  output logic [STATE_W-1:0] cur_state,
  output logic               dom_on,
  output logic               clk_on,
  output logic               mod_clk_en,
  output logic               mod_lrst
);
  assign clk_on = dom_on && (cur_state == MS_ENABLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_state  <= MS_OFF;
      dom_on     <= 1'b0;
      mod_clk_en <= 1'b0;
      mod_lrst   <= 1'b1;
    end else begin
      if (done) begin
        cur_state <= req_state;
        dom_on    <= req_dom_on;
      end
      mod_clk_en <= clk_on;
      mod_lrst   <= !lrst_release || (cur_state == MS_OFF) ||
                    (cur_state == MS_SYNCRST);
    end
  end
endmodule

// File: rtl/pwrslp_regfile.sv
module pwrslp_regfile
  import pwrslp_pkg::*;
#(
  parameter int DOM_ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               busy,
  input  logic [STATE_W-1:0] cur_state,
  input  logic               dom_on,
  input  logic               clk_on,
  output logic               start,
  output logic [STATE_W-1:0] req_state,
  output logic               req_dom_on,
  output logic               lrst_release
);
  logic              force_bit;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign start = bus_wr && (bus_addr == OFS_GO) && bus_wdata[DOM_ID] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_state    <= '0;
      req_dom_on   <= 1'b0;
      lrst_release <= 1'b0;
      force_bit    <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_MCTL) begin
        req_state    <= bus_wdata[STATE_W-1:0];
        lrst_release <= bus_wdata[LRSTN_BIT];
        force_bit    <= bus_wdata[FORCE_BIT];
      end
      if (bus_addr == OFS_DCTL) req_dom_on <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      OFS_BUSY:  rd_word[DOM_ID] = busy;
      OFS_DSTAT: rd_word[0] = dom_on;
      OFS_DCTL:  rd_word[0] = req_dom_on;
      OFS_MSTAT: begin
        rd_word[STATE_W-1:0] = cur_state;
        rd_word[CLKON_BIT]   = clk_on;
      end
      OFS_MCTL: begin
        rd_word[STATE_W-1:0] = req_state;
        rd_word[LRSTN_BIT]   = lrst_release;
        rd_word[FORCE_BIT]   = force_bit;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/pwrslp_ctrl.sv
module pwrslp_ctrl
  import pwrslp_pkg::*;
#(
  parameter int DOM_ID      = 0,
  parameter int XFER_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mod_clk_en,
  output logic              mod_lrst
);
  logic               start, busy, done;
  logic [STATE_W-1:0] req_state, cur_state;
  logic               req_dom_on, lrst_release, dom_on, clk_on;

  pwrslp_xfer_seq #(.XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  pwrslp_regfile #(.DOM_ID(DOM_ID)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .cur_state(cur_state), .dom_on(dom_on), .clk_on(clk_on),
    .start(start), .req_state(req_state), .req_dom_on(req_dom_on),
    .lrst_release(lrst_release)
  );

  pwrslp_state u_state (
    .clk(clk), .rst(rst), .done(done), .req_state(req_state),
    .req_dom_on(req_dom_on), .lrst_release(lrst_release),
    .cur_state(cur_state), .dom_on(dom_on), .clk_on(clk_on),
    .mod_clk_en(mod_clk_en), .mod_lrst(mod_lrst)
  );
endmodule

// File: rtl/pwrslp_chk.sv
module pwrslp_chk
  import pwrslp_pkg::*;
#(
  parameter int DOM_ID = 0
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] cur_state,
  input logic               dom_on,
  input logic               lrst_release,
  input logic               mod_clk_en,
  input logic               mod_lrst
);
  logic go_hit;
  assign go_hit = bus_wr && (bus_addr == OFS_GO) && bus_wdata[DOM_ID];

  a_r4_go_starts: assert property (@(posedge clk) disable iff (rst)
    (!busy && go_hit) |=> busy);

  a_r6_no_stray_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go_hit) |=> !busy);

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(cur_state) && $stable(dom_on)));

  a_r8_clk_en_rule: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mod_clk_en == ($past(dom_on) && ($past(cur_state) == MS_ENABLE))));

  a_r9_lrst_rule: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mod_lrst == (!$past(lrst_release) || ($past(cur_state) < 6'd2))));
endmodule

bind pwrslp_ctrl pwrslp_chk #(.DOM_ID(DOM_ID)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .done(done), .cur_state(cur_state),
  .dom_on(dom_on), .lrst_release(lrst_release), .mod_clk_en(mod_clk_en),
  .mod_lrst(mod_lrst)
);

// File: tb/sim_pwrslp_ctrl.sv
`timescale 1ns/1ps
module sim_pwrslp_ctrl;
  localparam int XFER = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mod_clk_en, mod_lrst;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwrslp_ctrl #(.DOM_ID(0), .XFER_CYCLES(XFER)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_lrst(mod_lrst)
  );

  // Behavioural reference model
  bit [31:0] m_mctl, m_rdata;
  bit        m_dctl, m_dom, m_busy, m_clk, m_lrst;
  int        m_state, m_cnt;

  function automatic bit [31:0] model_read(input bit [11:0] a);
    bit [31:0] w = 0;
    case (a)
      12'h128: w[0] = m_busy;
      12'h200: w[0] = m_dom;
      12'h300: w[0] = m_dctl;
      12'h800: begin w[5:0] = m_state[5:0]; w[12] = m_dom && (m_state == 3); end
      12'hA00: w = m_mctl;
      default: w = 0;
    endcase
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mctl = 0; m_rdata = 0; m_dctl = 0; m_dom = 0; m_busy = 0;
      m_clk = 0; m_lrst = 1; m_state = 0; m_cnt = 0;
    end else begin
      bit [31:0] rd_n;
      bit clk_n, lrst_n, busy_n, dom_n;
      int cnt_n, st_n;
      rd_n   = bus_rd ? model_read(bus_addr) : m_rdata;
      clk_n  = m_dom && (m_state == 3);
      lrst_n = !m_mctl[8] || (m_state < 2);
      busy_n = m_busy; cnt_n = m_cnt; dom_n = m_dom; st_n = m_state;
      if (m_busy) begin
        if (m_cnt == 0) begin busy_n = 0; dom_n = m_dctl; st_n = int'(m_mctl[5:0]); end
        else cnt_n = m_cnt - 1;
      end else if (bus_wr && bus_addr == 12'h120 && bus_wdata[0]) begin
        busy_n = 1; cnt_n = XFER - 1;
      end
      if (bus_wr && bus_addr == 12'hA00) m_mctl = bus_wdata & 32'h8000_013F;
      if (bus_wr && bus_addr == 12'h300) m_dctl = bus_wdata[0];
      m_rdata = rd_n; m_clk = clk_n; m_lrst = lrst_n;
      m_busy = busy_n; m_cnt = cnt_n; m_dom = dom_n; m_state = st_n;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R8 mod_clk_en", {31'b0, mod_clk_en}, {31'b0, m_clk});
      check("R9 mod_lrst", {31'b0, mod_lrst}, {31'b0, m_lrst});
      check("R10 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic go_and_wait();
    wr(12'h120, 32'h1);
    repeat (XFER + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ones;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 clk_en", {31'b0, mod_clk_en}, 32'h0);
    check("R1 lrst", {31'b0, mod_lrst}, 32'h1);
    rd(12'h200, v); check("R1 dstat", v, 32'h0);
    rd(12'h800, v); check("R1 mstat", v, 32'h0);
    rd(12'hA00, v); check("R1 mctl", v, 32'h0);
    rd(12'h300, v); check("R1 dctl", v, 32'h0);
    rd(12'h128, v); check("R1 busy", v, 32'h0);
    // R2 / R3 stored bits
    wr(12'hA00, 32'hFFFF_FFFF); rd(12'hA00, v); check("R2 mctl mask", v, 32'h8000_013F);
    wr(12'h300, 32'hFFFF_FFFE); rd(12'h300, v); check("R3 dctl bit0 clear", v, 32'h0);
    wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, v); check("R3 dctl mask", v, 32'h1);
    wr(12'hA00, 32'h8000_0103); rd(12'hA00, v); check("R2 mctl readback", v, 32'h8000_0103);
    // R6 foreign domain bit
    wr(12'h120, 32'hFFFF_FFFE); rd(12'h128, v); check("R6 foreign go", v, 32'h0);
    rd(12'h800, v); check("R6 state unchanged", v, 32'h0);
    // R4 exact busy length, R6 repeat command, R5 hold
    wr(12'h120, 32'h1);
    ones = 0;
    for (int k = 0; k < 12; k++) begin
      if (k == 3) begin
        bus_wr = 1; bus_addr = 12'h120; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
        ones++;
        continue;
      end
      if (k == 5) begin rd(12'h800, v); check("R5 no early change", v, 32'h0); ones++; continue; end
      rd(12'h128, v);
      if (v[0]) ones++;
    end
    check("R4 busy cycles", ones, XFER);
    rd(12'h128, v); check("R4 idle after", v, 32'h0);
    rd(12'h200, v); check("R5 domain on", v, 32'h1);
    rd(12'h800, v); check("R7 enabled status", v, 32'h0000_1003);
    check("R8 clk_en on", {31'b0, mod_clk_en}, 32'h1);
    check("R9 lrst off", {31'b0, mod_lrst}, 32'h0);
    // Disabled, local reset held; force cleared has no effect
    wr(12'hA00, 32'h0000_0002); go_and_wait();
    rd(12'h800, v); check("R5 disabled status", v, 32'h2);
    check("R8 clk_en off", {31'b0, mod_clk_en}, 32'h0);
    check("R9 lrst held", {31'b0, mod_lrst}, 32'h1);
    // Enabled with domain going off
    wr(12'hA00, 32'h0000_0103); wr(12'h300, 32'h0); go_and_wait();
    rd(12'h200, v); check("R5 domain off", v, 32'h0);
    rd(12'h800, v); check("R7 no clock when domain off", v, 32'h3);
    check("R8 clk_en domain off", {31'b0, mod_clk_en}, 32'h0);
    // Sync reset, release set, domain on
    wr(12'hA00, 32'h0000_0101); wr(12'h300, 32'h1); go_and_wait();
    check("R9 lrst in sync reset", {31'b0, mod_lrst}, 32'h1);
    // Enabled with local reset held, force set
    wr(12'hA00, 32'h8000_0003); go_and_wait();
    check("R8 clk_en with lrst", {31'b0, mod_clk_en}, 32'h1);
    check("R9 lrst from ctl bit", {31'b0, mod_lrst}, 32'h1);
    wr(12'hA00, 32'h8000_0103);
    repeat (2) @(negedge clk);
    check("R2 force no effect", {30'b0, mod_clk_en, mod_lrst}, 32'h2);
    // R10 unmapped and hold
    rd(12'h124, v); check("R10 unmapped", v, 32'h0);
    rd(12'h120, v); check("R10 go reads zero", v, 32'h0);
    rd(12'hA00, v);
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 32'h8000_0103);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule